// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block sits between a flash controller's sequencing logic and an 8-bit NAND flash bus. A local requester asks for one operation at a time: latch a command byte, send a complete five-byte address, write a run of data bytes, or read a run of data bytes. The block turns each request into a train of write-enable or read-enable pulses. Command-latch and address-latch are held at the levels that tell the flash what kind of byte each pulse carries, and chip enable stays low for the whole operation. The setup, strobe-low and hold times are runtime inputs counted in system clocks. Each phase lasts its programmed value plus one clock.

The address request takes a 12-bit column and a 17-bit row and expands them into five bus bytes with zeros in the unused upper bits. Write data is pulled from the requester one byte at a time through a take strobe. Read data is returned with a one-cycle valid strobe. The bidirectional data bus is split into an output value, an output enable and an input value. The enable is high only while the block is driving command, address or write bytes. The ready/busy line from the flash passes through a two-flop synchronizer. After every write-enable pulse it is also masked for a programmable number of clocks, so that the flash has time to pull it low.

Top module: `nand_bus_engine`

## Requirements
- R1: While reset is applied and right after it is released, chip enable is high, command-latch and address-latch are low, both strobes are high, the data output enable is low, done is low and req_ready is high.
- R2: A request with req_op = 0 (command) produces exactly one write-enable pulse with command-latch high and address-latch low. req_cmd is on the data bus when write-enable rises.
- R3: A request with req_op = 1 (address) produces five write-enable pulses with address-latch high and command-latch low. The bytes, in order, are col[7:0], {4'b0, col[11:8]}, row[7:0], row[15:8] and {7'b0, row[16]}.
- R4: A request with req_op = 2 (write) produces req_len write-enable pulses with both latch signals low. wr_take is high in the cycle before each clock edge that consumes wr_data, and the bytes appear on the bus in consumption order.
- R5: A request with req_op = 3 (read) produces req_len read-enable pulses, with a length of 0 treated as 1. At the last clock of each read-enable low phase, the flash data input is captured to rd_data and rd_valid pulses for one cycle.
- R6: Before each strobe the bus spends t_setup+1 clocks in setup. Each strobe stays low for t_pulse+1 clocks. Between consecutive strobes of one operation there are t_hold+t_setup+2 clocks.
- R7: The data output enable is high at every write-enable rising edge. It is low whenever read-enable is low, and it is already low in the clock before read-enable falls.
- R8: flash_ready is high only when the ready/busy input has been high through two synchronizing flops and at least t_blank clocks have passed since the last write-enable rising edge. A change on the ready/busy input reaches flash_ready on the second clock edge.
- R9: req_ready is low while an operation is in progress. done pulses for exactly one cycle when the last hold phase ends, and in that cycle chip enable is high and req_ready is high again.
- R10: Command-latch and address-latch are never high together, and chip enable is low whenever a strobe is low.
- R11: The write-protect output is the inverse of the write_protect input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Engine idle; request accepted when valid and ready |
| req_op | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_cmd | input | 8 | Command byte for a command request |
| req_col | input | 12 | Column address for an address request |
| req_row | input | 17 | Row address for an address request |
| req_len | input | 12 | Byte count for write and read requests |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | wr_data is consumed at the coming clock edge |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| done | output | 1 | One-cycle pulse at the end of an operation |
| t_setup | input | 4 | Setup clocks minus one |
| t_pulse | input | 4 | Strobe-low clocks minus one |
| t_hold | input | 4 | Hold clocks minus one |
| t_blank | input | 8 | Ready/busy blanking clocks after a write-enable pulse |
| write_protect | input | 1 | Assert flash write protection |
| flash_ready | output | 1 | Synchronized, blanked ready indication |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | Data bus output value |
| nand_io_oe | output | 1 | Data bus output enable |
| nand_io_in | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy from flash, low means busy |

## Verification
The assertions assume that the timing inputs do not change during an operation. They also assume that the ready/busy line does not reach flash_ready sooner than two clocks after it changes. The bench changes t_setup, t_pulse, t_hold and t_blank only between operations, when req_ready is high, and picks each from a small random range under a fixed seed. The ready/busy input stays high through the random traffic and is pulled low only in a final directed sequence. Write bytes, read bytes, lengths, columns and rows are random. Directed cases cover the top column 2111, a row with its top bit set, single-byte writes and reads of length 0.

// File: rtl/nand_bus_engine.sv
module nand_bus_engine #(
  parameter int TW  = 4,
  parameter int BW  = 8,
  parameter int LW  = 12,
  parameter int CW  = 12,
  parameter int RWD = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [7:0]     req_cmd,
  input  logic [CW-1:0]  req_col,
  input  logic [RWD-1:0] req_row,
  input  logic [LW-1:0]  req_len,
  input  logic [7:0]     wr_data,
  output logic           wr_take,
  output logic [7:0]     rd_data,
  output logic           rd_valid,
  output logic           done,
  input  logic [TW-1:0]  t_setup,
  input  logic [TW-1:0]  t_pulse,
  input  logic [TW-1:0]  t_hold,
  input  logic [BW-1:0]  t_blank,
  input  logic           write_protect,
  output logic           flash_ready,
  output logic           nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic           nand_wp_n,
  output logic [7:0]     nand_io_out,
  output logic           nand_io_oe,
  input  logic [7:0]     nand_io_in,
  input  logic           nand_rb_n
);
  localparam logic [1:0] OP_CMD = 2'd0;
  localparam logic [1:0] OP_ADR = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [1:0] OP_RD  = 2'd3;
  localparam int         NADR   = 5;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD} st_t;

  st_t             state;
  logic [TW-1:0]   cnt;
  logic [LW-1:0]   rem;
  logic [1:0]      op_q;
  logic [2:0]      idx;
  logic [7:0]      io_q;
  logic [CW-1:0]   col_q;
  logic [RWD-1:0]  row_q;
  logic [BW-1:0]   blank;
  logic            rb_s1, rb_s2;

  function automatic logic [7:0] adr_byte(input logic [2:0] i,
                                          input logic [CW-1:0] c,
                                          input logic [RWD-1:0] r);
    logic [15:0] cw;
    logic [23:0] rw;
    cw = 16'(c);
    rw = 24'(r);
    case (i)
      3'd0:    return cw[7:0];
      3'd1:    return {4'h0, cw[11:8]};
      3'd2:    return rw[7:0];
      3'd3:    return rw[15:8];
      default: return {7'h0, rw[16]};
    endcase
  endfunction

  wire busy     = (state != S_IDLE);
  wire accept   = req_valid && !busy;
  wire cnt_zero = (cnt == '0);
  wire last     = (rem == LW'(1));
  wire hold_end = (state == S_HOLD) && cnt_zero;
  wire is_rd    = (op_q == OP_RD);

  assign wr_take = (accept && req_op == OP_WR) ||
                   (hold_end && !last && op_q == OP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rem      <= '0;
      op_q     <= OP_CMD;
      idx      <= '0;
      io_q     <= '0;
      col_q    <= '0;
      row_q    <= '0;
      blank    <= '0;
      rb_s1    <= 1'b0;
      rb_s2    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rb_s1    <= nand_rb_n;
      rb_s2    <= rb_s1;
      if (blank != '0) blank <= blank - BW'(1);
      case (state)
        S_IDLE: if (accept) begin
          op_q  <= req_op;
          col_q <= req_col;
          row_q <= req_row;
          idx   <= '0;
          cnt   <= t_setup;
          state <= S_SETUP;
          case (req_op)
            OP_CMD:  begin rem <= LW'(1);    io_q <= req_cmd; end
            OP_ADR:  begin rem <= LW'(NADR); io_q <= adr_byte(3'd0, req_col, req_row); end
            OP_WR:   begin rem <= (req_len == '0) ? LW'(1) : req_len; io_q <= wr_data; end
            default: begin rem <= (req_len == '0) ? LW'(1) : req_len; end
          endcase
        end
        S_SETUP: if (cnt_zero) begin
          cnt   <= t_pulse;
          state <= S_PULSE;
        end else cnt <= cnt - TW'(1);
        S_PULSE: if (cnt_zero) begin
          cnt   <= t_hold;
          state <= S_HOLD;
          if (is_rd) begin
            rd_data  <= nand_io_in;
            rd_valid <= 1'b1;
          end else blank <= t_blank;
        end else cnt <= cnt - TW'(1);
        default: if (cnt_zero) begin
          if (last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            rem   <= rem - LW'(1);
            idx   <= idx + 3'd1;
            cnt   <= t_setup;
            state <= S_SETUP;
            if (op_q == OP_ADR) io_q <= adr_byte(idx + 3'd1, col_q, row_q);
            else if (op_q == OP_WR) io_q <= wr_data;
          end
        end else cnt <= cnt - TW'(1);
      endcase
    end
  end

  assign req_ready   = !busy;
  assign nand_ce_n   = !busy;
  assign nand_cle    = busy && (op_q == OP_CMD);
  assign nand_ale    = busy && (op_q == OP_ADR);
  assign nand_we_n   = !((state == S_PULSE) && !is_rd);
  assign nand_re_n   = !((state == S_PULSE) && is_rd);
  assign nand_io_oe  = busy && !is_rd;
  assign nand_io_out = io_q;
  assign nand_wp_n   = !write_protect;
  assign flash_ready = rb_s2 && (blank == '0);
endmodule

// File: rtl/nand_bus_engine_checker.sv
module nand_bus_engine_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic flash_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_io_oe,
  input logic nand_rb_n
);
  assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_ce_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_oe_off_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  assert_oe_released_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> !$past(nand_io_oe));

  assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_rb_synced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ready |-> $past(nand_rb_n, 2));
endmodule

bind nand_bus_engine nand_bus_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .flash_ready(flash_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_io_oe(nand_io_oe), .nand_rb_n(nand_rb_n)
);

// File: tb/nand_bus_engine_bench.sv
`timescale 1ns/1ps
module nand_bus_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_cmd = 8'h00;
  logic [11:0] req_col = '0;
  logic [16:0] req_row = '0;
  logic [11:0] req_len = '0;
  logic [7:0] wr_data;
  logic [3:0] t_setup = 4'd0, t_pulse = 4'd0, t_hold = 4'd0;
  logic [7:0] t_blank = 8'd0;
  logic write_protect = 1'b0;
  logic [7:0] nand_io_in = 8'h00;
  logic nand_rb_n = 1'b1;
  logic req_ready, wr_take, rd_valid, done, flash_ready;
  logic [7:0] rd_data, nand_io_out;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;

  always #4 clk = ~clk;

  nand_bus_engine u_nand_bus_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cmd(req_cmd), .req_col(req_col), .req_row(req_row),
    .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .t_setup(t_setup), .t_pulse(t_pulse),
    .t_hold(t_hold), .t_blank(t_blank), .write_protect(write_protect),
    .flash_ready(flash_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_wp_n(nand_wp_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [0:15];
  logic [7:0] rd_mem [0:15];
  logic [7:0] exp_b [0:15];
  logic [1:0] exp_k [0:15];
  logic [7:0] log_b [0:63];
  logic [1:0] log_k [0:63];
  logic       log_oe [0:63];
  int log_n = 0, wr_idx = 0, rd_ptr = 0, rd_chk = 0;
  int hi_n = 0, lo_n = 0, bk = 1000, bset = 0;
  bit first_s = 1'b1, prev_s = 1'b1, prev_oe = 1'b0, prev_we = 1'b1, blank_en = 1'b1;

  assign wr_data = wbuf[wr_idx[3:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] exp_addr(input int i, input logic [11:0] c, input logic [16:0] r);
    case (i)
      0: return c[7:0];
      1: return {4'h0, c[11:8]};
      2: return r[7:0];
      3: return r[15:8];
      default: return {7'h0, r[16]};
    endcase
  endfunction

  // flash model: log every byte latched by a write-enable rising edge
  always @(posedge nand_we_n) if (rst_n && !nand_ce_n && log_n < 64) begin
    log_b[log_n] = nand_io_out;
    log_k[log_n] = {nand_cle, nand_ale};
    log_oe[log_n] = nand_io_oe;
    log_n++;
  end

  // flash model: present the next byte after each read-enable falling edge
  always @(negedge nand_re_n) if (rst_n) begin
    #1 nand_io_in = rd_mem[rd_ptr[3:0]];
    rd_ptr++;
  end

  always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 1;

  always @(negedge clk) if (rst_n && rd_valid) begin
    chk(rd_data == rd_mem[rd_chk[3:0]], "R5 read byte", rd_data, rd_mem[rd_chk[3:0]]);
    rd_chk++;
  end

  // strobe timing monitor (R6) and output-enable release (R7)
  always @(negedge clk) if (rst_n) begin
    bit s;
    s = nand_we_n & nand_re_n;
    if (nand_ce_n) begin
      hi_n = 0; lo_n = 0; first_s = 1'b1;
    end else begin
      if (!s && prev_s) begin
        int e;
        e = first_s ? int'(t_setup) + 1 : int'(t_hold) + int'(t_setup) + 2;
        chk(hi_n == e, "R6 gap before strobe", hi_n, e);
        if (!nand_re_n) chk(!nand_io_oe && !prev_oe, "R7 oe released before read strobe", int'(prev_oe), 0);
        first_s = 1'b0; lo_n = 0;
      end
      if (s && !prev_s) begin
        chk(lo_n == int'(t_pulse) + 1, "R6 strobe width", lo_n, int'(t_pulse) + 1);
        hi_n = 0;
      end
      if (s) hi_n++; else lo_n++;
    end
    prev_s = s;
    prev_oe = nand_io_oe;
  end

  // blanking monitor (R8)
  always @(negedge clk) if (rst_n) begin
    if (!prev_we && nand_we_n) begin bk = 0; bset = int'(t_blank); end
    else if (bk < 1000) bk++;
    if (blank_en && bk <= bset + 3)
      chk(flash_ready == (bk >= bset), "R8 ready blanking", int'(flash_ready), int'(bk >= bset));
    prev_we = nand_we_n;
  end

  task automatic set_t(input int s, input int p, input int h, input int b);
    @(posedge clk); #1;
    t_setup = 4'(s); t_pulse = 4'(p); t_hold = 4'(h); t_blank = 8'(b);
  endtask

  task automatic run_op(input int op, input logic [7:0] cb, input logic [11:0] col,
                        input logic [16:0] row, input int len);
    int nexp, nb, t;
    nb = (len == 0) ? 1 : len;
    nexp = 0;
    case (op)
      0: begin exp_b[0] = cb; exp_k[0] = 2'b10; nexp = 1; end
      1: begin for (int i = 0; i < 5; i++) begin exp_b[i] = exp_addr(i, col, row); exp_k[i] = 2'b01; end nexp = 5; end
      2: begin for (int i = 0; i < 16; i++) begin wbuf[i] = 8'($urandom); if (i < nb) begin exp_b[i] = wbuf[i]; exp_k[i] = 2'b00; end end nexp = nb; end
      default: for (int i = 0; i < 16; i++) rd_mem[i] = 8'($urandom);
    endcase
    log_n = 0; rd_ptr = 0; rd_chk = 0;
    @(posedge clk); #1;
    wr_idx = 0;
    req_op = 2'(op); req_cmd = cb; req_col = col; req_row = row; req_len = 12'(len);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done && req_ready && nand_ce_n, "R9 done with idle bus", int'({done, req_ready, nand_ce_n}), 7);
    chk(log_n == nexp, "R10 write-enable pulse count", log_n, nexp);
    for (int i = 0; i < nexp && i < log_n; i++) begin
      string rq;
      rq = (op == 0) ? "R2 command byte" : (op == 1) ? "R3 address byte" : "R4 write byte";
      chk(log_b[i] == exp_b[i], rq, log_b[i], exp_b[i]);
      chk(log_k[i] == exp_k[i], "R10 latch levels", log_k[i], exp_k[i]);
      chk(log_oe[i], "R7 oe at write strobe", int'(log_oe[i]), 1);
    end
    if (op == 2) chk(wr_idx == nb, "R4 wr_take count", wr_idx, nb);
    if (op == 3) begin
      chk(rd_chk == nb, "R5 rd_valid count", rd_chk, nb);
      chk(rd_ptr == nb, "R5 read strobe count", rd_ptr, nb);
    end
    @(negedge clk);
    chk(!done, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 16; i++) begin wbuf[i] = 8'h00; rd_mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    chk(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_io_oe && !done && req_ready,
        "R1 reset state", int'({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, done, req_ready}), 8'b10011001);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_io_oe && !done && req_ready,
        "R1 after reset", int'({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, done, req_ready}), 8'b10011001);
    repeat (2) @(negedge clk);
    chk(flash_ready, "R8 ready after sync", int'(flash_ready), 1);
    chk(nand_wp_n, "R11 write protect off", int'(nand_wp_n), 1);
    #1 write_protect = 1'b1;
    @(negedge clk);
    chk(!nand_wp_n, "R11 write protect on", int'(nand_wp_n), 0);
    #1 write_protect = 1'b0;

    set_t(0, 0, 0, 6);  run_op(0, 8'h70, '0, '0, 0);
    set_t(1, 2, 1, 10); run_op(1, 8'h00, 12'd2111, 17'h1ABCD, 0);
    set_t(0, 0, 0, 3);  run_op(1, 8'h00, 12'd0, 17'h10000, 0);
    set_t(2, 0, 3, 0);  run_op(2, 8'h00, '0, '0, 1);
    set_t(0, 1, 0, 0);  run_op(3, 8'h00, '0, '0, 0);
    set_t(1, 1, 1, 4);  run_op(2, 8'h00, '0, '0, 16);
    set_t(3, 2, 1, 0);  run_op(3, 8'h00, '0, '0, 16);

    for (int n = 0; n < 60; n++) begin
      int op, ln;
      op = int'($urandom % 4);
      ln = int'($urandom % 13);
      if (op == 2 && ln == 0) ln = 1;
      set_t(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 16));
      run_op(op, 8'($urandom), 12'($urandom % 2112), 17'($urandom), ln);
    end

    repeat (40) @(negedge clk);
    blank_en = 1'b0;
    @(posedge clk); #1 nand_rb_n = 1'b0;
    @(negedge clk);
    chk(flash_ready, "R8 busy not yet synced (1)", int'(flash_ready), 1);
    @(negedge clk);
    chk(flash_ready, "R8 busy not yet synced (2)", int'(flash_ready), 1);
    @(negedge clk);
    chk(!flash_ready, "R8 busy seen", int'(flash_ready), 0);
    @(posedge clk); #1 nand_rb_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!flash_ready, "R8 ready not yet synced", int'(flash_ready), 0);
    @(negedge clk);
    chk(flash_ready, "R8 ready seen", int'(flash_ready), 1);
    finish_up();
  end
endmodule